// File: doc/BRIEF.md
# Two-Pulse Interrupt Acknowledge Sequencer

This block turns an accepted maskable interrupt request into the bus sequence that fetches an interrupt vector from a cascaded interrupt controller. When it sees a request while idle, it runs two acknowledge bus operations. Each operation has one status clock followed by one or more command clocks. The acknowledge strobe is low during the command clocks, and a command phase ends on the clock in which ready is sampled high. A fixed run of idle clocks separates the two operations.

The first operation carries no vector. Its only job is to let the master controller pick which slave will answer. During the status clock of that first operation the block drives the active-low lock output. It also holds off external hold grants from the first status clock until the second operation ends. A cascade-enable output is high during both operations, so that slave-select addresses can be driven onto the address bus. The second operation always takes at least one forced wait clock, whatever ready does. It captures the vector from the low data byte on its last command clock, and the vector-valid pulse follows one clock later.

Top module: `intack_seq`

## Requirements
- R1: While reset is asserted and after it is released, the outputs rest idle: ack_n=1, lock_n=1, cas_en=0, hold_blk=0, vec_vld=0.
- R2: A request (irq=1) sampled while idle starts the sequence. The next clock is the first operation's status clock, with ack_n=1.
- R3: The first operation's command phase drives ack_n=0 from the clock after its status clock. It ends with the clock in which rdy is sampled high, and no vector is captured in it.
- R4: Exactly GAP_CLKS (default 3) clocks separate the two operations, with ack_n=1 and cas_en=0 whatever rdy does.
- R5: The second operation has one status clock (ack_n=1), then FORCED_WAITS (default 1) clocks with ack_n=0 in which rdy is ignored. After that, ack_n stays 0 until the clock in which rdy is sampled high, inclusive.
- R6: cas_en=1 on every status and command clock of both operations, and 0 otherwise.
- R7: hold_blk=1 from the first status clock through the last command clock of the second operation, and 0 on the clock after.
- R8: vec takes din[7:0] as sampled on the last command clock of the second operation. vec_vld=1 for exactly the following clock, and vec then holds until the next capture.
- R9: irq has no effect while a sequence is active. An irq sampled in the idle clock that carries vec_vld starts a new sequence on the next clock.
- R10: lock_n=0 only on the first operation's status clock (exactly one clock per sequence), and 1 on all other clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq | input | 1 | Maskable interrupt request, accepted only while idle |
| rdy | input | 1 | Bus ready, ends a command phase when high |
| din | input | VEC_W | Data bus low byte carrying the vector |
| ack_n | output | 1 | Active-low acknowledge strobe |
| lock_n | output | 1 | Active-low bus lock |
| cas_en | output | 1 | Cascade address drive enable |
| hold_blk | output | 1 | High while external hold grants must be withheld |
| vec | output | VEC_W | Captured interrupt vector |
| vec_vld | output | 1 | One-clock pulse marking a fresh vector |

## Verification
The vector-valid pulse and the acceptance of a new request can fall in the same clock. That clock is the idle clock right after capture, so it can both report the old vector and start the next sequence. The bench provokes this by holding irq high straight through a whole sequence. It then judges that vec_vld=1 with hold_blk=0 in that clock, and that the next clock shows lock_n=0 and hold_blk=1 with vec unchanged. The sweep over first- and second-operation wait counts also checks that a request held high mid-sequence never restarts the sequence.

// File: rtl/intack_pkg.sv
package intack_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_A1_STAT = 3'd1,
    ST_A1_CMD  = 3'd2,
    ST_GAP     = 3'd3,
    ST_A2_STAT = 3'd4,
    ST_A2_WAIT = 3'd5,
    ST_A2_CMD  = 3'd6
  } seq_st_e;
endpackage

// File: rtl/intack_ctrl.sv
module intack_ctrl
  import intack_pkg::*;
#(
  parameter int GAP_CLKS     = 3,
  parameter int FORCED_WAITS = 1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    irq,
  input  logic    rdy,
  output seq_st_e st,
  output logic    cap_en
);
  localparam int MAXC = (GAP_CLKS > FORCED_WAITS) ? GAP_CLKS : FORCED_WAITS;
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC + 1);
  localparam logic [CW-1:0] GAP_LD  = CW'(GAP_CLKS - 1);
  localparam logic [CW-1:0] WAIT_LD = CW'(FORCED_WAITS - 1);

  seq_st_e       st_nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          cnt_en;

  // next-state logic
  always_comb begin
    st_nxt  = st;
    cnt_nxt = cnt;
    cnt_en  = 1'b0;
    cap_en  = 1'b0;
    unique case (st)
      ST_IDLE:    if (irq) st_nxt = ST_A1_STAT;
      ST_A1_STAT: st_nxt = ST_A1_CMD;
      ST_A1_CMD: if (rdy) begin
        st_nxt  = ST_GAP;
        cnt_nxt = GAP_LD;
        cnt_en  = 1'b1;
      end
      ST_GAP: begin
        if (cnt == '0) st_nxt = ST_A2_STAT;
        else begin
          cnt_nxt = cnt - 1'b1;
          cnt_en  = 1'b1;
        end
      end
      ST_A2_STAT: begin
        st_nxt  = ST_A2_WAIT;
        cnt_nxt = WAIT_LD;
        cnt_en  = 1'b1;
      end
      ST_A2_WAIT: begin
        if (cnt == '0) st_nxt = ST_A2_CMD;
        else begin
          cnt_nxt = cnt - 1'b1;
          cnt_en  = 1'b1;
        end
      end
      ST_A2_CMD: if (rdy) begin
        st_nxt = ST_IDLE;
        cap_en = 1'b1;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end

  // counter register with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/intack_decode.sv
module intack_decode
  import intack_pkg::*;
(
  input  seq_st_e st,
  output logic    ack_n,
  output logic    lock_n,
  output logic    cas_en,
  output logic    hold_blk
);
  always_comb begin
    ack_n    = 1'b1;
    lock_n   = 1'b1;
    cas_en   = 1'b0;
    hold_blk = (st != ST_IDLE);
    unique case (st)
      ST_A1_STAT: begin
        lock_n = 1'b0;
        cas_en = 1'b1;
      end
      ST_A1_CMD, ST_A2_WAIT, ST_A2_CMD: begin
        ack_n  = 1'b0;
        cas_en = 1'b1;
      end
      ST_A2_STAT: cas_en = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/intack_vcap.sv
module intack_vcap #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [VEC_W-1:0] din,
  output logic [VEC_W-1:0] vec,
  output logic             vec_vld
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec <= '0;
    else if (cap_en) vec <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_vld <= 1'b0;
    else        vec_vld <= cap_en;
  end
endmodule

// File: rtl/intack_seq.sv
module intack_seq
  import intack_pkg::*;
#(
  parameter int VEC_W        = 8,
  parameter int GAP_CLKS     = 3,
  parameter int FORCED_WAITS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq,
  input  logic             rdy,
  input  logic [VEC_W-1:0] din,
  output logic             ack_n,
  output logic             lock_n,
  output logic             cas_en,
  output logic             hold_blk,
  output logic [VEC_W-1:0] vec,
  output logic             vec_vld
);
  logic [1:0] rst_sync;
  logic       rst_int_n;
  seq_st_e    st;
  logic       cap_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  intack_ctrl #(.GAP_CLKS(GAP_CLKS), .FORCED_WAITS(FORCED_WAITS)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .irq    (irq),
    .rdy    (rdy),
    .st     (st),
    .cap_en (cap_en)
  );

  intack_decode u_dec (
    .st       (st),
    .ack_n    (ack_n),
    .lock_n   (lock_n),
    .cas_en   (cas_en),
    .hold_blk (hold_blk)
  );

  intack_vcap #(.VEC_W(VEC_W)) u_vcap (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cap_en  (cap_en),
    .din     (din),
    .vec     (vec),
    .vec_vld (vec_vld)
  );
endmodule

// File: rtl/intack_chk.sv
module intack_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_n,
  input logic             lock_n,
  input logic             cas_en,
  input logic             hold_blk,
  input logic [VEC_W-1:0] vec,
  input logic             vec_vld
);
  // R10: lock lasts one clock
  a_r10_lock_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_n |=> lock_n);
  // R2: lock only opens a sequence that was idle before
  a_r2_lock_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_n) |-> !$past(hold_blk));
  // R7: strobe only while hold is blocked
  a_r7_ack_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> hold_blk);
  // R6: cascade enable covers every strobe clock
  a_r6_cas_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> cas_en);
  // R8: valid is a single-clock pulse
  a_r8_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld |=> !vec_vld);
  // R8: valid follows the end of the hold-blocked window
  a_r8_vld_after_seq: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld |-> (!hold_blk && $past(hold_blk)));
  // R8: vector only changes with a valid pulse
  a_r8_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_vld |-> $stable(vec));
endmodule

bind intack_seq intack_chk #(.VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack_n    (ack_n),
  .lock_n   (lock_n),
  .cas_en   (cas_en),
  .hold_blk (hold_blk),
  .vec      (vec),
  .vec_vld  (vec_vld)
);

// File: tb/sim_intack_seq.sv
`timescale 1ns/1ps
module sim_intack_seq;
  localparam int GAP = 3;
  localparam int FW  = 1;

  logic       clk = 1'b0;
  logic       rst_n, irq, rdy;
  logic [7:0] din;
  logic       ack_n, lock_n, cas_en, hold_blk, vec_vld;
  logic [7:0] vec;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  intack_seq #(.VEC_W(8), .GAP_CLKS(GAP), .FORCED_WAITS(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .irq(irq), .rdy(rdy), .din(din),
    .ack_n(ack_n), .lock_n(lock_n), .cas_en(cas_en), .hold_blk(hold_blk),
    .vec(vec), .vec_vld(vec_vld)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    check({tag, " ack_n"},    32'(ack_n),    32'd1);
    check({tag, " lock_n"},   32'(lock_n),   32'd1);
    check({tag, " cas_en"},   32'(cas_en),   32'd0);
    check({tag, " hold_blk"}, 32'(hold_blk), 32'd0);
    check({tag, " vec_vld"},  32'(vec_vld),  32'd0);
  endtask

  // one full sequence; w1/w2 = extra ready-low command clocks
  task automatic run_seq(input int w1, input int w2, input bit keep);
    int e1, s2, last;
    logic [7:0] expv;
    e1   = 1 + w1;
    s2   = e1 + GAP + 1;
    last = s2 + FW + 1 + w2;
    expv = vec;
    @(negedge clk);
    irq = 1'b1; rdy = 1'b0; din = 8'h00;
    for (int t = 0; t <= last + 2; t++) begin
      @(negedge clk);
      if (keep && t == last + 2) begin
        check("R9 restart lock_n", 32'(lock_n),   32'd0);
        check("R9 restart hold",   32'(hold_blk), 32'd1);
        check("R9 restart ack_n",  32'(ack_n),    32'd1);
        check("R8 vec held",       32'(vec),      32'(expv));
      end else begin
        logic e_ack, e_cas;
        e_ack = !((t >= 1 && t <= e1) || (t >= s2 + 1 && t <= last));
        e_cas = (t <= e1) || (t >= s2 && t <= last);
        if (t <= e1)      check("R3 ack_n", 32'(ack_n), 32'(e_ack));
        else if (t < s2)  check("R4 ack_n", 32'(ack_n), 32'(e_ack));
        else              check("R5 ack_n", 32'(ack_n), 32'(e_ack));
        if (t == 0) check("R2 lock_n", 32'(lock_n), 32'd0);
        else        check("R10 lock_n", 32'(lock_n), 32'd1);
        if (t > e1 && t < s2) check("R4 cas_en", 32'(cas_en), 32'(e_cas));
        else                  check("R6 cas_en", 32'(cas_en), 32'(e_cas));
        if (t == last + 2) check("R9 no restart hold", 32'(hold_blk), 32'd0);
        else               check("R7 hold_blk", 32'(hold_blk), 32'(t <= last));
        check("R8 vec_vld", 32'(vec_vld), 32'(t == last + 1));
        if (t >= last + 1 || t <= e1) check("R8 vec", 32'(vec), 32'(expv));
      end
      // drive for this clock
      irq = keep ? 1'b1 : (t < last);
      rdy = (t == e1) || (t > e1 && t < s2) || (t > s2 && t <= s2 + FW) || (t == last);
      din = 8'(t * 37 + w1 * 11 + w2 * 5 + 3);
      if (t == last) expv = din;
    end
    irq = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R1 watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq = 1'b0; rdy = 1'b0; din = 8'h00;
    repeat (3) @(negedge clk);
    irq = 1'b1; rdy = 1'b1;
    @(negedge clk);
    check_idle("R1 in reset");
    check("R1 vec", 32'(vec), 32'd0);
    irq = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1 after release");
    for (int w1 = 0; w1 < 4; w1++)
      for (int w2 = 0; w2 < 4; w2++) begin
        run_seq(w1, w2, 1'b0);
        @(negedge clk);
        check_idle("R9 between");
      end
    run_seq(2, 1, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    check_idle("R1 reset mid-sequence");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule